// File: doc/BRIEF.md
# Manchester Line Transmitter with Training Preamble

This block turns one parallel character into a Manchester-coded waveform on a single serial line. Each bit time is split into two half-bit slots, and the line level changes at mid-bit so that a receiver can recover the clock from the data. A slot lasts until the next pulse on the half-bit tick input, which comes from an external baud generator.

Every character goes out as a frame with three parts. First comes an optional training preamble of 0 to 15 bit times, drawn from one of four fixed patterns. Next comes a start delimiter. The delimiter is either a single coded start bit or a three-bit-time sync shape that breaks the Manchester rules. The eight data bits follow. A polarity input swaps the two transition directions used for coded bits.

The host hands over a character with a valid/ready handshake. Ready is high only while the block is idle. The framing settings are captured together with the byte, so the host may change them while a frame is on the line.

Top module: `manch_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_o` is high, `busy_o` is low and `ready_o` is high. Tick pulses while idle leave the line high.
- R2: A character is taken at a clock edge where `valid_i` and `ready_o` are both high. From the next cycle `busy_o` is high and `ready_o` is low until the frame ends. The first half-bit slot of the frame appears on `tx_o` in that same cycle.
- R3: During a frame, the line moves to the next half-bit slot only at a clock edge where `tick_i` is high. Without a tick, `tx_o` holds its level.
- R4: With `pol_i` = 0, a coded 0 is sent low in the first half and high in the second half. A coded 1 is sent high in the first half and low in the second half.
- R5: With `pol_i` = 1, every coded bit is inverted: a 0 is sent high then low, and a 1 is sent low then high.
- R6: The data field has 8 coded bits, 16 half-bit slots in all, sent least significant bit first.
- R7: The preamble lasts `pre_len_i` bit times and comes before the delimiter. A length of 0 sends no preamble.
- R8: `pre_pat_i` selects the preamble bits, counting bit index k from 0. The codes are: 2'b00 all ones; 2'b01 all zeros; 2'b10 one when k is even and zero when k is odd; 2'b11 zero when k is even and one when k is odd. Each preamble bit is coded as in R4/R5.
- R9: With `sync_i` = 0, the delimiter is one coded 0 (two slots), coded as in R4/R5.
- R10: With `sync_i` = 1, the delimiter is six slots long: high for three slots, then low for three slots. This shape does not depend on `pol_i`.
- R11: The byte, pattern, length, polarity and delimiter mode are captured at acceptance. Changing them during a frame, or raising `valid_i` during a frame, has no effect on that frame.
- R12: At the clock edge that ends the last data slot, the block returns to idle: `tx_o` high, `busy_o` low, `ready_o` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Half-bit timing pulse |
| valid_i | input | 1 | Character offered |
| data_i | input | 8 | Character to send |
| ready_o | output | 1 | Idle; can accept a character |
| pre_pat_i | input | 2 | Preamble pattern select |
| pre_len_i | input | 4 | Preamble length in bit times |
| pol_i | input | 1 | Manchester polarity select |
| sync_i | input | 1 | Delimiter mode: 0 coded start bit, 1 sync shape |
| tx_o | output | 1 | Serial line |
| busy_o | output | 1 | Frame in progress |

## Verification
The bench sweeps every pattern code against preamble lengths 0, 1, 2, 5 and 15, in both polarities and both delimiter modes. For each frame it builds the expected slot sequence arithmetically and compares it slot by slot. The length sweep separates a missing preamble from an off-by-one bit count. The two alternating patterns are told apart only by their first bit, and the polarity sweep shows whether the inversion reaches the preamble, the coded start bit and the data while leaving the sync shape unchanged. Data bytes vary from frame to frame, so a reversed bit order shows up. After acceptance the bench scrambles every framing input and raises valid, which exposes any setting that is read live instead of latched.

// File: rtl/manch_pkg.sv
`timescale 1ns/1ps
package manch_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_PRE, PH_SFD, PH_DATA} phase_e;
  typedef enum logic [1:0] {PAT_ONES, PAT_ZEROS, PAT_ONE_ZERO, PAT_ZERO_ONE} pat_e;
endpackage

// File: rtl/manch_seq.sv
`timescale 1ns/1ps
module manch_seq
  import manch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4,
  parameter int CNT_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              accept_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [1:0]        pat_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              pol_i,
  input  logic              sync_i,
  output phase_e            phase_o,
  output logic [CNT_W-1:0]  cnt_o,
  output pat_e              pat_o,
  output logic              pol_o,
  output logic              sync_o,
  output logic              bit_o
);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(2 * DATA_W - 1);

  phase_e             phase_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [DATA_W-1:0]  sh_q;
  logic [LEN_W-1:0]   len_q;
  pat_e               pat_q;
  logic               pol_q, sync_q;
  logic [CNT_W-1:0]   last_cnt;
  logic               slot_last;

  always_comb begin
    unique case (phase_q)
      PH_PRE:  last_cnt = CNT_W'({len_q, 1'b0}) - CNT_W'(1);
      PH_SFD:  last_cnt = sync_q ? CNT_W'(5) : CNT_W'(1);
      default: last_cnt = DATA_LAST;
    endcase
    slot_last = (cnt_q == last_cnt);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      len_q   <= '0;
      pat_q   <= PAT_ONES;
      pol_q   <= 1'b0;
      sync_q  <= 1'b0;
    end else if (accept_i) begin
      phase_q <= (len_i != '0) ? PH_PRE : PH_SFD;
      cnt_q   <= '0;
      sh_q    <= data_i;
      len_q   <= len_i;
      pat_q   <= pat_e'(pat_i);
      pol_q   <= pol_i;
      sync_q  <= sync_i;
    end else if (tick_i && phase_q != PH_IDLE) begin
      if (slot_last) begin
        cnt_q <= '0;
        unique case (phase_q)
          PH_PRE:  phase_q <= PH_SFD;
          PH_SFD:  phase_q <= PH_DATA;
          default: phase_q <= PH_IDLE;
        endcase
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
      // shift after the second half of each data bit
      if (phase_q == PH_DATA && cnt_q[0]) sh_q <= sh_q >> 1;
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;
  assign pat_o   = pat_q;
  assign pol_o   = pol_q;
  assign sync_o  = sync_q;
  assign bit_o   = sh_q[0];

  // R7: the preamble is never entered with a zero length
  p_pre_len_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_PRE) |-> (len_q != '0));
endmodule

// File: rtl/manch_line.sv
`timescale 1ns/1ps
module manch_line
  import manch_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  phase_e           phase_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  pat_e             pat_i,
  input  logic             pol_i,
  input  logic             sync_i,
  input  logic             bit_i,
  output logic             tx_o
);
  logic pre_bit;

  // cnt_i[1] is the parity of the preamble bit index
  always_comb begin
    unique case (pat_i)
      PAT_ONES:     pre_bit = 1'b1;
      PAT_ZEROS:    pre_bit = 1'b0;
      PAT_ONE_ZERO: pre_bit = ~cnt_i[1];
      default:      pre_bit = cnt_i[1];
    endcase
  end

  always_comb begin
    unique case (phase_i)
      PH_PRE:  tx_o = pre_bit ^ pol_i ^ cnt_i[0];
      PH_SFD:  tx_o = sync_i ? (cnt_i < CNT_W'(3)) : (pol_i ^ cnt_i[0]);
      PH_DATA: tx_o = bit_i ^ pol_i ^ cnt_i[0];
      default: tx_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/manch_tx.sv
`timescale 1ns/1ps
module manch_tx
  import manch_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  input  logic [1:0]        pre_pat_i,
  input  logic [LEN_W-1:0]  pre_len_i,
  input  logic              pol_i,
  input  logic              sync_i,
  output logic              tx_o,
  output logic              busy_o
);
  localparam int PRE_HALVES = 2 * ((1 << LEN_W) - 1);
  localparam int DAT_HALVES = 2 * DATA_W;
  localparam int MAX_HALVES = (PRE_HALVES > DAT_HALVES) ? PRE_HALVES :
                              ((DAT_HALVES > 6) ? DAT_HALVES : 6);
  localparam int CNT_W      = $clog2(MAX_HALVES);

  phase_e           phase;
  logic [CNT_W-1:0] cnt;
  pat_e             pat;
  logic             pol, sync_mode, dbit, accept;

  assign ready_o = (phase == PH_IDLE);
  assign busy_o  = ~ready_o;
  assign accept  = valid_i & ready_o;

  manch_seq #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .accept_i (accept),
    .data_i   (data_i),
    .pat_i    (pre_pat_i),
    .len_i    (pre_len_i),
    .pol_i    (pol_i),
    .sync_i   (sync_i),
    .phase_o  (phase),
    .cnt_o    (cnt),
    .pat_o    (pat),
    .pol_o    (pol),
    .sync_o   (sync_mode),
    .bit_o    (dbit)
  );

  manch_line #(.CNT_W(CNT_W)) u_line (
    .phase_i (phase),
    .cnt_i   (cnt),
    .pat_i   (pat),
    .pol_i   (pol),
    .sync_i  (sync_mode),
    .bit_i   (dbit),
    .tx_o    (tx_o)
  );

  p_idle_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> tx_o);

  p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> busy_o);

  p_hold_no_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !tick_i) |=> $stable(tx_o));

  // R4/R5: every coded bit flips the line at mid-bit
  p_mid_transition_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && tick_i && !cnt[0] && !(phase == PH_SFD && sync_mode))
      |=> (tx_o != $past(tx_o)));

  p_end_on_tick_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(tick_i));
endmodule

// File: tb/tb_manch_tx.sv
`timescale 1ns/1ps
module tb_manch_tx;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, valid = 1'b0;
  logic [7:0] data = '0;
  logic [1:0] pat = '0;
  logic [3:0] len = '0;
  logic       pol = 1'b0, sync = 1'b0;
  logic       tx, ready, busy;

  int total = 0, bad = 0;
  bit done = 0;
  logic  exp_lv [64];
  string exp_tag[64];
  int    n_exp;

  always #2 clk = ~clk;

  manch_tx dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .valid_i(valid), .data_i(data),
    .ready_o(ready), .pre_pat_i(pat), .pre_len_i(len), .pol_i(pol), .sync_i(sync),
    .tx_o(tx), .busy_o(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic lv, input string tag);
    exp_lv[n_exp]  = lv;
    exp_tag[n_exp] = tag;
    n_exp++;
  endtask

  task automatic build(input logic [1:0] p, input int l, input logic po,
                       input logic sy, input logic [7:0] d);
    logic b;
    n_exp = 0;
    for (int k = 0; k < l; k++) begin
      case (p)
        2'b00: b = 1'b1;
        2'b01: b = 1'b0;
        2'b10: b = (k % 2 == 0);
        default: b = (k % 2 == 1);
      endcase
      push(b ^ po, "R7/R8 preamble");
      push(~(b ^ po), "R7/R8 preamble");
    end
    if (sy) begin
      for (int h = 0; h < 6; h++) push(h < 3, "R10 sync");
    end else begin
      push(po, "R9 start bit");
      push(~po, "R9 start bit");
    end
    for (int i = 0; i < 8; i++) begin
      push(d[i] ^ po, po ? "R5/R6 data" : "R4/R6 data");
      push(~(d[i] ^ po), po ? "R5/R6 data" : "R4/R6 data");
    end
  endtask

  task automatic send(input logic [1:0] p, input int l, input logic po,
                      input logic sy, input logic [7:0] d);
    build(p, l, po, sy, d);
    @(negedge clk);
    pat = p; len = 4'(l); pol = po; sync = sy; data = d; valid = 1'b1;
    chk(ready == 1'b1, "R2 ready before accept", int'(ready), 1);
    @(negedge clk);
    valid = 1'b0;
    chk(busy == 1'b1 && ready == 1'b0, "R2 busy after accept", int'(busy), 1);
    // R11: scramble every input after acceptance
    pat = ~p; len = ~4'(l); pol = ~po; sync = ~sy; data = ~d;
    for (int h = 0; h < n_exp; h++) begin
      chk(tx === exp_lv[h], exp_tag[h], int'(tx), int'(exp_lv[h]));
      if (h == 0) begin
        @(negedge clk);  // R3: no tick, slot held
        chk(tx === exp_lv[0], "R3 hold without tick", int'(tx), int'(exp_lv[0]));
      end
      if (h == 2) valid = 1'b1;
      if (h == 3) begin
        chk(ready == 1'b0, "R11 ready low mid-frame", int'(ready), 0);
        valid = 1'b0;
      end
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
    chk(tx == 1'b1 && busy == 1'b0 && ready == 1'b1, "R12 return to idle",
        int'({tx, busy, ready}), 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int f;
    int lens[5];
    lens = '{0, 1, 2, 5, 15};
    f = 0;
    repeat (3) @(negedge clk);
    chk(tx == 1'b1 && busy == 1'b0 && ready == 1'b1, "R1 reset state",
        int'({tx, busy, ready}), 5);
    rst_n = 1'b1;
    @(negedge clk);
    repeat (4) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0;
      chk(tx == 1'b1 && busy == 1'b0, "R1 tick while idle", int'({tx, busy}), 2);
    end
    for (int p = 0; p < 4; p++)
      for (int li = 0; li < 5; li++)
        for (int po = 0; po < 2; po++)
          for (int sy = 0; sy < 2; sy++) begin
            send(2'(p), lens[li], po[0], sy[0], 8'((f * 53 + 17) & 255));
            f++;
          end
    send(2'b10, 3, 1'b0, 1'b0, 8'h00);
    send(2'b11, 3, 1'b1, 1'b1, 8'hFF);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule